// File: doc/BRIEF.md
# Trace Address Comparator Qualifier

This block holds a bank of single-address comparators for an instruction trace unit. Each comparator owns a 64-bit address value register and an access-type register. Every cycle, each implemented comparator tests the current instruction address against its value. Address bits 1:0 take no part in the test. The raw hit is then qualified in two ways. The first is a per-state, per-exception-level disable mask, where a set bit suppresses the comparator. The second is an optional dependency on one of eight external context-identifier comparators, one of eight virtual-context-identifier comparators, or both. The qualified hits are registered and presented as a 16-bit match vector.

Software programs the comparators through a simple register port with a write strobe, a read strobe, a register select, a comparator index and 64-bit data. Reads return data one cycle later. An index at or above the implemented count raises a one-cycle access error. Register writes are honoured only while the trace unit reports idle. All programmable fields reset to zero.

Top module: `trace_addr_qual`

## Requirements
- R1: An access-type read returns zero in bits 63:15, bit 7 and bits 1:0, whatever was written; with both context comparator kinds present, writing all ones reads back 64'h7F7C.
- R2: Comparator i raises cmp_match[i] one clock after an address whose bits 63:2 equal its value register bits 63:2; address bits 1:0 are ignored, and a difference in any other bit gives no match.
- R3: Access-type bits 14, 13 and 12 disable comparator i in non-secure EL2, EL1 and EL0. Bits 11, 10, 9 and 8 disable it in secure EL3, EL2, EL1 and EL0. A 1 disables and a 0 enables. Non-secure with cur_el = 3 never matches.
- R4: Access-type bits 3:2 set the context dependency and bits 6:4 pick the slot k. 00 means none. 01 needs ctx_hit[k]. 10 needs vctx_hit[k]. 11 needs both.
- R5: With no context-identifier comparators, bit 2 reads zero and has no effect. With no virtual-context comparators, bit 3 reads zero and has no effect. With neither kind, bits 6:4 also read zero.
- R6: The implemented count is 2*NUM_PAIRS. A read or write at cfg_idx >= that count sets cfg_err one clock later with cfg_rdata zero and changes nothing. Match bits at and above the count stay zero.
- R7: A write made while unit_idle is low changes no register.
- R8: After reset all value and access-type fields are zero, cmp_match is zero, and an address of zero in any enabled state matches every implemented comparator.
- R9: A value-register read (cfg_sel = 0) returns all 64 written bits one clock after cfg_rd; cfg_sel = 1 selects the access-type register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_sel | input | 1 | 0 = address value register, 1 = access-type register |
| cfg_idx | input | 4 | Comparator index |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data, valid one clock after cfg_rd |
| cfg_err | output | 1 | Access to an unimplemented index, one clock after the strobe |
| unit_idle | input | 1 | Trace unit idle; writes are accepted only when high |
| pc_addr | input | 64 | Current instruction address |
| cur_el | input | 2 | Current exception level |
| cur_ns | input | 1 | 1 = non-secure state |
| ctx_hit | input | 8 | Context-identifier comparator results |
| vctx_hit | input | 8 | Virtual-context-identifier comparator results |
| cmp_match | output | 16 | Registered per-comparator match |

## Verification
The main test programs a single comparator and drives its address with every low-bit offset. It also drives flipped high and low address bits, which separates the real compare from the ignored bits. A vector table and a sweep walk every exception level, both security states and all four dependency codes. The sweep varies the disable masks and applies context-hit patterns where only the selected slot, or every slot except that one, is set, so an indexing error or an inverted disable sense shows up in the match bit. A second instance built without context comparators shows the dependency bits read as zero and gate nothing. Directed tests cover out-of-range indices and writes made while the unit is busy.

// File: rtl/taq_pkg.sv
package taq_pkg;

  localparam int MAX_CMP   = 16;
  localparam int CTX_SLOTS = 8;

  typedef enum logic [1:0] {
    DEP_NONE = 2'b00,
    DEP_CID  = 2'b01,
    DEP_VCID = 2'b10,
    DEP_BOTH = 2'b11
  } ctx_dep_e;

  // lvl_off[3:0] secure EL0..EL3, lvl_off[6:4] non-secure EL0..EL2
  typedef struct packed {
    logic [6:0] lvl_off;
    logic [2:0] ctx_sel;
    ctx_dep_e   dep;
  } acc_type_t;

  function automatic logic [63:0] type_wmask(input bit has_cid, input bit has_vcid);
    logic [63:0] m;
    m = 64'h7F00;
    if (has_cid)             m = m | 64'h0004;
    if (has_vcid)            m = m | 64'h0008;
    if (has_cid || has_vcid) m = m | 64'h0070;
    return m;
  endfunction

  function automatic logic [63:0] type_to_reg(input acc_type_t t);
    return {49'b0, t.lvl_off, 1'b0, t.ctx_sel, t.dep, 2'b00};
  endfunction

  function automatic logic el_permits(input acc_type_t t, input logic [1:0] el,
                                      input logic ns);
    if (ns && el == 2'd3) return 1'b0;
    return !t.lvl_off[{ns, el}];
  endfunction

  function automatic logic ctx_permits(input acc_type_t t, input logic [CTX_SLOTS-1:0] cid,
                                       input logic [CTX_SLOTS-1:0] vid);
    logic need_c, need_v;
    need_c = t.dep[0];
    need_v = t.dep[1];
    return (!need_c || cid[t.ctx_sel]) && (!need_v || vid[t.ctx_sel]);
  endfunction

endpackage

// File: rtl/taq_cfg_regs.sv
module taq_cfg_regs
  import taq_pkg::*;
#(
  parameter int NUM_CMP  = 8,
  parameter int ADDR_W   = 64,
  parameter bit HAS_CID  = 1'b1,
  parameter bit HAS_VCID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_sel,
  input  logic [3:0]        cfg_idx,
  input  logic [63:0]       cfg_wdata,
  input  logic              unit_idle,
  output logic [63:0]       cfg_rdata,
  output logic              cfg_err,
  output logic              wr_accept,
  output logic [ADDR_W-1:0] val_o [NUM_CMP],
  output acc_type_t         typ_o [NUM_CMP]
);

  localparam int  IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam bit  HAS_ANY = HAS_CID || HAS_VCID;

  logic [ADDR_W-1:0] val_q [NUM_CMP];
  acc_type_t         typ_q [NUM_CMP];
  logic              idx_ok;
  logic [IDX_W-1:0]  idx;
  acc_type_t         new_typ;
  logic [63:0]       rd_word;

  assign idx_ok    = int'(cfg_idx) < NUM_CMP;
  assign idx       = cfg_idx[IDX_W-1:0];
  assign wr_accept = cfg_wr && unit_idle && idx_ok;

  always_comb begin
    new_typ.lvl_off = cfg_wdata[14:8];
    new_typ.ctx_sel = HAS_ANY ? cfg_wdata[6:4] : 3'b000;
    new_typ.dep     = ctx_dep_e'({HAS_VCID ? cfg_wdata[3] : 1'b0,
                                  HAS_CID  ? cfg_wdata[2] : 1'b0});
  end

  always_comb begin
    if (cfg_sel) rd_word = type_to_reg(typ_q[idx]);
    else         rd_word = 64'(val_q[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        val_q[i] <= '0;
        typ_q[i] <= '0;
      end
    end else if (wr_accept) begin
      if (cfg_sel) typ_q[idx] <= new_typ;
      else         val_q[idx] <= cfg_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_rdata <= (cfg_rd && idx_ok) ? rd_word : '0;
      cfg_err   <= (cfg_rd || cfg_wr) && !idx_ok;
    end
  end

  assign val_o = val_q;
  assign typ_o = typ_q;

endmodule

// File: rtl/taq_cmp_unit.sv
module taq_cmp_unit
  import taq_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:2]    cmp_val,
  input  acc_type_t            cmp_typ,
  input  logic [ADDR_W-1:2]    pc_hi,
  input  logic [1:0]           cur_el,
  input  logic                 cur_ns,
  input  logic [CTX_SLOTS-1:0] ctx_hit,
  input  logic [CTX_SLOTS-1:0] vctx_hit,
  output logic                 lvl_ok,
  output logic                 hit
);

  logic addr_eq;
  logic ctx_ok;

  assign addr_eq = (cmp_val == pc_hi);
  assign lvl_ok  = el_permits(cmp_typ, cur_el, cur_ns);
  assign ctx_ok  = ctx_permits(cmp_typ, ctx_hit, vctx_hit);
  assign hit     = addr_eq && lvl_ok && ctx_ok;

endmodule

// File: rtl/trace_addr_qual.sv
module trace_addr_qual
  import taq_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 64,
  parameter bit HAS_CID   = 1'b1,
  parameter bit HAS_VCID  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_idx,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  output logic        cfg_err,
  input  logic        unit_idle,
  input  logic [63:0] pc_addr,
  input  logic [1:0]  cur_el,
  input  logic        cur_ns,
  input  logic [7:0]  ctx_hit,
  input  logic [7:0]  vctx_hit,
  output logic [15:0] cmp_match
);

  localparam int NUM_CMP = 2 * NUM_PAIRS;

  logic [ADDR_W-1:0]  val_w [NUM_CMP];
  acc_type_t          typ_w [NUM_CMP];
  logic               wr_accept;
  logic [MAX_CMP-1:0] lvl_ok;
  logic [MAX_CMP-1:0] hit_raw;
  logic [1:0]         unused_pc_lo;

  assign unused_pc_lo = pc_addr[1:0];

  taq_cfg_regs #(
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W),
    .HAS_CID (HAS_CID),
    .HAS_VCID(HAS_VCID)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_sel  (cfg_sel),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .unit_idle(unit_idle),
    .cfg_rdata(cfg_rdata),
    .cfg_err  (cfg_err),
    .wr_accept(wr_accept),
    .val_o    (val_w),
    .typ_o    (typ_w)
  );

  for (genvar g = 0; g < MAX_CMP; g++) begin : g_cmp
    if (g < NUM_CMP) begin : g_live
      taq_cmp_unit #(.ADDR_W(ADDR_W)) u_cmp (
        .cmp_val (val_w[g][ADDR_W-1:2]),
        .cmp_typ (typ_w[g]),
        .pc_hi   (pc_addr[ADDR_W-1:2]),
        .cur_el  (cur_el),
        .cur_ns  (cur_ns),
        .ctx_hit (ctx_hit),
        .vctx_hit(vctx_hit),
        .lvl_ok  (lvl_ok[g]),
        .hit     (hit_raw[g])
      );
    end else begin : g_absent
      assign lvl_ok[g]  = 1'b0;
      assign hit_raw[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_match <= '0;
    else        cmp_match <= hit_raw;
  end

endmodule

// File: rtl/taq_checker.sv
module taq_checker
  import taq_pkg::*;
#(
  parameter int NUM_CMP  = 8,
  parameter bit HAS_CID  = 1'b1,
  parameter bit HAS_VCID = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        cfg_rd,
  input logic        cfg_sel,
  input logic [3:0]  cfg_idx,
  input logic [63:0] cfg_rdata,
  input logic        cfg_err,
  input logic [1:0]  cur_el,
  input logic        cur_ns,
  input logic [15:0] cmp_match,
  input logic [15:0] lvl_ok
);

  localparam logic [63:0] TMASK = type_wmask(HAS_CID, HAS_VCID);

  AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) && int'(cfg_idx) >= NUM_CMP |=> cfg_err);                // R6
  AST_GOOD_IDX_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) && int'(cfg_idx) < NUM_CMP |=> !cfg_err);                // R6
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_rdata == 64'd0);                                             // R6
  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_match >> NUM_CMP) == 16'd0);                                            // R6
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && cfg_sel |=> (cfg_rdata & ~TMASK) == 64'd0);                        // R1
  AST_NS_EL3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ns && cur_el == 2'd3 |=> cmp_match == 16'd0);                            // R3
  AST_LVL_GATES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_match & ~$past(lvl_ok)) == 16'd0);                                      // R3

endmodule

bind trace_addr_qual taq_checker #(
  .NUM_CMP (NUM_CMP),
  .HAS_CID (HAS_CID),
  .HAS_VCID(HAS_VCID)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_rd   (cfg_rd),
  .cfg_sel  (cfg_sel),
  .cfg_idx  (cfg_idx),
  .cfg_rdata(cfg_rdata),
  .cfg_err  (cfg_err),
  .cur_el   (cur_el),
  .cur_ns   (cur_ns),
  .cmp_match(cmp_match),
  .lvl_ok   (lvl_ok)
);

// File: tb/tb_trace_addr_qual.sv
module tb_trace_addr_qual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_sel = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic        unit_idle = 1'b1;
  logic [63:0] pc_addr = '0;
  logic [1:0]  cur_el = '0;
  logic        cur_ns = 1'b0;
  logic [7:0]  ctx_hit = '0, vctx_hit = '0;
  logic [63:0] cfg_rdata, nc_rdata;
  logic        cfg_err, nc_err;
  logic [15:0] cmp_match, nc_match;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] VAL = 64'h0000_1234_5678_9ABC;

  // {type[15:0], el[1:0], ns, cid[7:0], vid[7:0], alow[1:0], expected}
  localparam int NVEC = 15;
  localparam logic [37:0] VEC [NVEC] = '{
    {16'h0000, 2'd1, 1'b0, 8'h00, 8'h00, 2'd0, 1'b1},
    {16'h0000, 2'd2, 1'b1, 8'h00, 8'h00, 2'd3, 1'b1},
    {16'h0200, 2'd1, 1'b0, 8'h00, 8'h00, 2'd1, 1'b0},
    {16'h0200, 2'd1, 1'b1, 8'h00, 8'h00, 2'd2, 1'b1},
    {16'h2000, 2'd1, 1'b1, 8'h00, 8'h00, 2'd0, 1'b0},
    {16'h0000, 2'd3, 1'b1, 8'hFF, 8'hFF, 2'd0, 1'b0},
    {16'h0800, 2'd3, 1'b0, 8'h00, 8'h00, 2'd0, 1'b0},
    {16'h0024, 2'd0, 1'b0, 8'h04, 8'h00, 2'd0, 1'b1},
    {16'h0024, 2'd0, 1'b0, 8'h08, 8'hFF, 2'd0, 1'b0},
    {16'h0058, 2'd2, 1'b0, 8'h00, 8'h20, 2'd0, 1'b1},
    {16'h0058, 2'd2, 1'b0, 8'hFF, 8'hDF, 2'd0, 1'b0},
    {16'h007C, 2'd1, 1'b1, 8'h80, 8'h80, 2'd0, 1'b1},
    {16'h007C, 2'd1, 1'b1, 8'h80, 8'h7F, 2'd0, 1'b0},
    {16'h4000, 2'd2, 1'b1, 8'h00, 8'h00, 2'd0, 1'b0},
    {16'h0100, 2'd0, 1'b0, 8'h00, 8'h00, 2'd0, 1'b0}
  };

  always #4 clk = ~clk;

  trace_addr_qual dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .unit_idle(unit_idle), .pc_addr(pc_addr), .cur_el(cur_el), .cur_ns(cur_ns),
    .ctx_hit(ctx_hit), .vctx_hit(vctx_hit), .cmp_match(cmp_match)
  );

  trace_addr_qual #(.HAS_CID(1'b0), .HAS_VCID(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(nc_rdata), .cfg_err(nc_err),
    .unit_idle(unit_idle), .pc_addr(pc_addr), .cur_el(cur_el), .cur_ns(cur_ns),
    .ctx_hit(ctx_hit), .vctx_hit(vctx_hit), .cmp_match(nc_match)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [3:0] idx, input logic [63:0] d,
                           output logic err);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    err = cfg_err;
    cfg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, input logic [3:0] idx,
                          output logic [63:0] d, output logic err);
    cfg_rd = 1'b1; cfg_sel = sel; cfg_idx = idx;
    @(negedge clk);
    d = cfg_rdata; err = cfg_err;
    cfg_rd = 1'b0;
  endtask

  task automatic apply(input logic [63:0] pc, input logic [1:0] el, input logic ns,
                       input logic [7:0] c, input logic [7:0] v);
    pc_addr = pc; cur_el = el; cur_ns = ns; ctx_hit = c; vctx_hit = v;
    @(negedge clk);
  endtask

  function automatic bit ref_hit(input logic [15:0] t, input int el, input int ns,
                                 input logic [7:0] c, input logic [7:0] v);
    int  k;
    bit  allowed;
    k = int'(t[6:4]);
    if (ns != 0) allowed = (el == 3) ? 1'b0 : (t[12 + el] == 1'b0);
    else         allowed = (t[8 + el] == 1'b0);
    if (t[2] && !c[k]) return 1'b0;
    if (t[3] && !v[k]) return 1'b0;
    return allowed;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic        er;

    pc_addr = 64'hDEAD_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    check("R8 match after reset", 64'(cmp_match), 64'd0);
    reg_read(1'b1, 4'd3, rd, er);
    check("R8 type reset zero", rd, 64'd0);
    reg_read(1'b0, 4'd3, rd, er);
    check("R8 value reset zero", rd, 64'd0);
    apply(64'd0, 2'd0, 1'b0, 8'h00, 8'h00);
    check("R8 zero address hits all implemented", 64'(cmp_match), 64'h00FF);

    // R2: program comparator 0, mismatches in high and second bit
    reg_write(1'b0, 4'd0, VAL, er);
    apply(VAL ^ 64'h4, 2'd1, 1'b0, 8'h00, 8'h00);
    check("R2 bit2 differs no match", 64'(cmp_match), 64'd0);
    apply(VAL ^ (64'd1 << 63), 2'd1, 1'b0, 8'h00, 8'h00);
    check("R2 bit63 differs no match", 64'(cmp_match), 64'd0);
    apply(VAL, 2'd1, 1'b0, 8'h00, 8'h00);
    check("R2 exact match", 64'(cmp_match), 64'h1);

    // Vector table: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] e;
      e = VEC[i];
      reg_write(1'b1, 4'd0, {48'd0, e[37:22]}, er);
      apply(VAL | {62'd0, e[2:1]}, e[21:20], e[19], e[18:11], e[10:3]);
      check($sformatf("R3/R4 vector %0d", i), 64'(cmp_match), {63'd0, e[0]});
    end

    // Sweep: R3 R4 against reference model
    for (int ct = 0; ct < 4; ct++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int el = 0; el < 4; el++) begin
          for (int ns = 0; ns < 2; ns++) begin
            logic [15:0] t;
            logic [15:0] masks [4];
            logic [7:0]  c, v;
            masks = '{16'h0000, 16'h7F00, 16'h5500, 16'h2A00};
            t = masks[mi] | 16'h0030 | 16'(ct << 2);
            c = ((el + ns) % 2 == 1) ? 8'h08 : 8'hF7;
            v = (el >= 2) ? 8'h08 : 8'h00;
            reg_write(1'b1, 4'd0, {48'd0, t}, er);
            apply(VAL, 2'(el), 1'(ns), c, v);
            check($sformatf("R3/R4 sweep t=%h el=%0d ns=%0d", t, el, ns),
                  64'(cmp_match), {63'd0, ref_hit(t, el, ns, c, v)});
          end
        end
      end
    end

    // R1: reserved bits read zero
    reg_write(1'b1, 4'd2, '1, er);
    reg_read(1'b1, 4'd2, rd, er);
    check("R1 type all ones readback", rd, 64'h7F7C);
    // R5: instance without context comparators
    check("R5 no-context readback", nc_rdata, 64'h7F00);

    // R9: full value readback
    reg_write(1'b0, 4'd2, 64'hA5C3_0F1E_8877_6655, er);
    reg_read(1'b0, 4'd2, rd, er);
    check("R9 value readback", rd, 64'hA5C3_0F1E_8877_6655);
    check("R9 valid read no error", 64'(er), 64'd0);

    // R5: dependency bits have no effect without context comparators
    reg_write(1'b1, 4'd0, 64'h007C, er);
    apply(VAL, 2'd1, 1'b0, 8'h00, 8'h00);
    check("R5 no-context instance matches", 64'(nc_match), 64'h1);
    check("R4 dependent instance blocked", 64'(cmp_match), 64'h0);

    // R6: unimplemented indices
    reg_read(1'b0, 4'd9, rd, er);
    check("R6 read bad index error", 64'(er), 64'd1);
    check("R6 read bad index data", rd, 64'd0);
    reg_write(1'b0, 4'd12, VAL, er);
    check("R6 write bad index error", 64'(er), 64'd1);
    reg_write(1'b1, 4'd0, 64'h0000, er);
    apply(VAL, 2'd0, 1'b0, 8'h00, 8'h00);
    check("R6 upper match bits zero", 64'(cmp_match), 64'h1);

    // R7: busy writes ignored
    unit_idle = 1'b0;
    reg_write(1'b1, 4'd0, 64'h0200, er);
    reg_write(1'b0, 4'd0, 64'h0, er);
    unit_idle = 1'b1;
    reg_read(1'b1, 4'd0, rd, er);
    check("R7 busy type write ignored", rd, 64'd0);
    reg_read(1'b0, 4'd0, rd, er);
    check("R7 busy value write ignored", rd, VAL);
    apply(VAL, 2'd1, 1'b0, 8'h00, 8'h00);
    check("R7 match unchanged after busy write", 64'(cmp_match), 64'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule